// File: doc/BRIEF.md
# Clock-Policy Eviction Frame Selector

This block tracks, for every physical page frame in a fully associative pool, a single "recently used" bit. It uses those bits to pick a frame to evict when the memory-management logic asks for one. Any frame may be a victim, so the block approximates least-recently-used replacement. It does this with one bit per frame and a rotating pointer, with no ordered history.

A memory access marks its frame as used by pulsing the access strobe with the frame index. System software periodically pulses a clear strobe that wipes every used bit. A victim request enters through a valid/ready handshake. The request is accepted only while the block is idle (`req_ready` high). The block then walks the frames from its rotating pointer, one frame per clock. Each used frame it passes loses its bit. The first unused frame is returned on a valid/ready response port, and the pointer moves one place past it. The response holds its frame index steady until the consumer raises `rsp_ready`. No new request is accepted before that. Writing back dirty data and fetching the new page are left to the surrounding logic.

Top module: `frame_evict_clock`

## Requirements
- R1: After reset every used bit is clear, the rotating pointer is at frame 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An access pulse (`acc_valid`=1 with `acc_frame`=f) sets the used bit of frame f at the next clock edge, so a later search passes over f.
- R3: A clear pulse (`clr_all`=1) clears every used bit at the next clock edge.
- R4: An access to frame f wins over a clear of f in the same cycle, whether that clear comes from `clr_all` or from the search passing f; f's bit stays set.
- R5: The returned frame is the first frame with a clear used bit, searched upward from the pointer and wrapping from frame N-1 to frame 0. Every used frame passed on the way has its bit cleared.
- R6: After a response the pointer sits one frame past the returned frame (frame N-1 wraps to 0).
- R7: If all N used bits are set, the search clears all of them and returns the frame where the pointer started. After N passed frames the frame at the pointer is returned even if it was marked again meanwhile.
- R8: With k used frames passed before the victim, `rsp_valid` rises k+1 clock edges after the edge that accepts the request, and never later than N+1 edges.
- R9: `rsp_valid` stays high with `rsp_frame` unchanged while `rsp_ready` is 0. `req_ready` is 0 from acceptance until the edge where the response is taken with `rsp_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Frame access strobe |
| acc_frame | input | IW (4) | Index of the accessed frame |
| clr_all | input | 1 | Clears every used bit |
| req_valid | input | 1 | Victim request valid |
| req_ready | output | 1 | Request can be accepted (block idle) |
| rsp_valid | output | 1 | Victim response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_frame | output | IW (4) | Index of the chosen victim frame |

## Verification
The search is tried with the used bits empty, with a short run of used frames just ahead of the pointer, with all bits set, and with all set but one frame behind the pointer. It is also tried with a run that forces a wrap past frame N-1. These cases separate the skip-and-clear walk, the wrap, the full-sweep fallback and the pointer advance, and each is timed against k+1 cycles. Directed cases cover an access and a clear landing together, an access held on the starting frame through a full sweep (the forced return), and a response held back by `rsp_ready`.

// File: rtl/fev_pkg.sv
package fev_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_SCAN = 2'd1,
    FS_RESP = 2'd2
  } fsm_e;
endpackage

// File: rtl/fev_refbits.sv
// One used bit per frame; set by access, cleared by clear-all or by the search.
module fev_refbits #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  input  logic          clr_all,
  input  logic          scan_clr,
  input  logic [IW-1:0] scan_idx,
  output logic [N-1:0]  ref_q
);
  logic [N-1:0] ref_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      ref_d[g] = ref_q[g];
      if (clr_all) ref_d[g] = 1'b0;
      if (scan_clr && scan_idx == IW'(g)) ref_d[g] = 1'b0;
      if (acc_valid && acc_frame == IW'(g)) ref_d[g] = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_q[g] <= 1'b0;
      else        ref_q[g] <= ref_d[g];
    end
  end

  // R2/R4: an access always leaves its bit set
  p_access_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ref_q[$past(acc_frame)]);
  // R3: a clear with no access empties the array
  p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !acc_valid) |=> (ref_q == '0));
endmodule

// File: rtl/fev_hand.sv
// Rotating pointer over the frame pool.
module fev_hand #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [IW-1:0] hand_q
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hand_q <= '0;
    else if (step) hand_q <= (hand_q == LAST) ? '0 : hand_q + 1'b1;
  end

  // R6: each step moves exactly one frame forward with wrap
  p_hand_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (hand_q == (($past(hand_q) == LAST) ? '0 : $past(hand_q) + 1'b1)));
  p_hand_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(hand_q));
endmodule

// File: rtl/fev_ctrl.sv
// Request/search/response sequencing.
module fev_ctrl
  import fev_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [IW-1:0] rsp_frame,
  input  logic          cur_used,
  input  logic [IW-1:0] hand,
  output logic          step,
  output logic          scan_clr
);
  localparam int CW = IW + 1;
  localparam logic [CW-1:0] SWEEP = CW'(N);

  fsm_e          state_q;
  logic [CW-1:0] cnt_q;
  logic          pick;

  always_comb begin
    pick     = 1'b0;
    step     = 1'b0;
    scan_clr = 1'b0;
    if (state_q == FS_SCAN) begin
      step = 1'b1;
      if (!cur_used || cnt_q == SWEEP) pick = 1'b1;
      else                             scan_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FS_IDLE;
      cnt_q     <= '0;
      rsp_frame <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (req_valid) begin
          state_q <= FS_SCAN;
          cnt_q   <= '0;
        end
        FS_SCAN: if (pick) begin
          state_q   <= FS_RESP;
          rsp_frame <= hand;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        FS_RESP: if (rsp_ready) state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == FS_IDLE);
  assign rsp_valid = (state_q == FS_RESP);

  // R8: the search never passes more than N frames
  p_sweep_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SWEEP);
  // R9: a pending response holds its value
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_frame)));
  // R9: no acceptance while a response is pending
  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: rtl/frame_evict_clock.sv
module frame_evict_clock #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  input  logic          clr_all,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [IW-1:0] rsp_frame
);
  logic [N-1:0]  used;
  logic [IW-1:0] hand;
  logic          step;
  logic          scan_clr;
  logic          cur_used;

  assign cur_used = used[hand];

  fev_refbits #(.N(N), .IW(IW)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .clr_all(clr_all),
    .scan_clr(scan_clr), .scan_idx(hand), .ref_q(used)
  );

  fev_hand #(.N(N), .IW(IW)) u_hand (
    .clk(clk), .rst_n(rst_n), .step(step), .hand_q(hand)
  );

  fev_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_frame(rsp_frame),
    .cur_used(cur_used), .hand(hand), .step(step), .scan_clr(scan_clr)
  );

  // R5: a passed frame loses its bit unless an access re-marks it
  p_pass_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_clr && !(acc_valid && acc_frame == hand)) |=> !used[$past(hand)]);
endmodule

// File: tb/sim_frame_evict_clock.sv
module sim_frame_evict_clock;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [IW-1:0] acc_frame = '0;
  logic clr_all = 1'b0;
  logic req_valid = 1'b0;
  logic rsp_ready = 1'b0;
  logic req_ready, rsp_valid;
  logic [IW-1:0] rsp_frame;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frame_evict_clock #(.N(N), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .clr_all(clr_all), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_frame(rsp_frame)
  );

  // {used mask, expected victim, expected latency}; pointer carries over rows
  localparam logic [27:0] VEC [6] = '{
    {16'h0000, 4'd0, 8'd1},   // empty: pointer 0 -> 0
    {16'h0006, 4'd3, 8'd3},   // skip 1,2 -> 3
    {16'hFFFF, 4'd4, 8'd17},  // all set: start frame 4
    {16'hFFF7, 4'd3, 8'd15},  // wrap to the only clear frame
    {16'h0010, 4'd5, 8'd2},   // skip 4
    {16'hFFC0, 4'd0, 8'd11}   // 6..15 set, wrap to 0
  };

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic pulse_clear();
    clr_all = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_all = 1'b0;
  endtask

  task automatic mark(input logic [15:0] m);
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        acc_valid = 1'b1; acc_frame = IW'(i);
        @(posedge clk); @(negedge clk);
      end
    end
    acc_valid = 1'b0;
  endtask

  task automatic ask(output int vic, output int lat);
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    vic = rsp_frame;
  endtask

  task automatic take();
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", req_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);

    for (int r = 0; r < 6; r++) begin
      pulse_clear();
      mark(VEC[r][27:12]);
      check("R9 ready before request", req_ready, 1);
      ask(v, l);
      check("R5/R7 victim", v, int'(VEC[r][11:8]));
      check("R8 latency", l, int'(VEC[r][7:0]));
      take();
    end
    // pointer now 1

    // R4: clear and access to frame 1 together; frame 1 stays used
    mark(16'hFFFF);
    clr_all = 1'b1; acc_valid = 1'b1; acc_frame = 4'd1;
    @(posedge clk); @(negedge clk);
    clr_all = 1'b0; acc_valid = 1'b0;
    ask(v, l);
    check("R4 victim skips marked frame", v, 2);
    check("R4/R3 latency", l, 2);
    take();
    // pointer 3, all bits clear (R5 cleared frame 1)

    // R9: hold the response
    ask(v, l);
    check("R5 passed bit cleared", v, 3);
    check("R8 latency one", l, 1);
    repeat (5) @(negedge clk);
    check("R9 valid held", rsp_valid, 1);
    check("R9 frame held", rsp_frame, 3);
    check("R9 busy", req_ready, 0);
    take();
    check("R9 ready after take", req_ready, 1);
    check("R9 valid dropped", rsp_valid, 0);
    // pointer 4

    // R7: all set, access held on start frame through the sweep
    mark(16'hFFFF);
    acc_valid = 1'b1; acc_frame = 4'd4;
    ask(v, l);
    check("R7 forced start frame", v, 4);
    check("R7 sweep latency", l, 17);
    acc_valid = 1'b0;
    take();
    // pointer 5; R6 and R7 cleared everything else
    ask(v, l);
    check("R6 pointer past victim", v, 5);
    check("R7 sweep cleared bits", l, 1);
    take();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule